// File: doc/BRIEF.md
# Mixed-Sign Multiplier Unit

This block multiplies two 16-bit operands in one of several sign interpretations using a single 17-bit by 17-bit signed multiply array. Before the array, each operand is widened by one bit. The extra bit is a copy of bit 15 when the mode treats that operand as signed. It is zero when the operand is unsigned. One array therefore serves signed, unsigned and both mixed-sign products.

Two further modes replace the second operand with a 5-bit unsigned literal, which is always zero-extended. A byte mode multiplies the low bytes of both operands as unsigned values and reports a 16-bit result.

A caller drives the operands, the literal and a mode code, then pulses a start strobe for one cycle. The unit captures these inputs on that edge. Exactly one clock later it presents the product together with a one-cycle valid strobe. The product stays on the output until the next start. A reserved mode code gives a zero product but still raises valid, so the caller never waits.

Top module: `mixed_mul_unit`

## Requirements
- R1: Mode code 0 treats both operands as 16-bit two's complement values; product_o is the 32-bit signed product.
- R2: Mode code 1 treats both operands as unsigned; product_o is the 32-bit unsigned product.
- R3: Mode code 2 multiplies unsigned op_a_i by signed op_b_i, and mode code 3 multiplies signed op_a_i by unsigned op_b_i; product_o holds the low 32 bits of the exact product.
- R4: Mode code 4 multiplies signed op_a_i, and mode code 5 multiplies unsigned op_a_i, by the zero-extended 5-bit lit_i. In these modes op_b_i has no effect on product_o.
- R5: Mode code 6 multiplies op_a_i[7:0] by op_b_i[7:0], both unsigned. The result sits in product_o[15:0] and product_o[31:16] is zero. Bits 15:8 of both operands have no effect.
- R6: Mode code 7 gives product_o equal to zero, and valid_o is still asserted.
- R7: valid_o is high in the cycle after each clock edge at which start_i is high, and low in every other cycle. Back-to-back starts give back-to-back results.
- R8: While rst_ni is low, and right after it is released, valid_o and product_o are zero.
- R9: product_o keeps its value during cycles in which no new result is issued, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture inputs and begin a multiply |
| mode_i | input | 3 | Mode code, 0 to 7 as listed in the requirements |
| op_a_i | input | 16 | First operand |
| op_b_i | input | 16 | Second operand |
| lit_i | input | 5 | Unsigned literal used by modes 4 and 5 |
| product_o | output | 32 | Product; upper half zero in byte mode |
| valid_o | output | 1 | Product valid, one cycle after start |

## Verification
The bench builds the unit with its default widths: 16-bit operands, a 5-bit literal and an 8-bit byte lane. These widths reach the array's true corners. Both operands at -32768 give 0x40000000, both at 0xFFFF unsigned give 0xFFFE0001, and 0xFFFF times -1 exercises the mixed modes, where a wrong extension bit is visible at once. Further directed cases drive nonzero upper bytes and stray second operands to show that byte and literal modes ignore them. Others issue back-to-back starts, a reserved mode code, and idle stretches with changing inputs to confirm the held output.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [2:0] {
    MD_SS  = 3'd0,
    MD_UU  = 3'd1,
    MD_US  = 3'd2,
    MD_SU  = 3'd3,
    MD_SL  = 3'd4,
    MD_UL  = 3'd5,
    MD_BB  = 3'd6,
    MD_RSV = 3'd7
  } mode_e;

  typedef struct packed {
    logic a_signed;
    logic b_signed;
    logic b_lit;
    logic byte_mode;
    logic legal;
  } ctl_t;
endpackage

// File: rtl/mmu_decode.sv
module mmu_decode
  import mmu_pkg::*;
(
  input  mode_e mode_i,
  output ctl_t  ctl_o
);
  always_comb begin
    ctl_o = '0;
    ctl_o.legal = 1'b1;
    unique case (mode_i)
      MD_SS: begin ctl_o.a_signed = 1'b1; ctl_o.b_signed = 1'b1; end
      MD_UU: ;
      MD_US: ctl_o.b_signed = 1'b1;
      MD_SU: ctl_o.a_signed = 1'b1;
      MD_SL: begin ctl_o.a_signed = 1'b1; ctl_o.b_lit = 1'b1; end
      MD_UL: ctl_o.b_lit = 1'b1;
      MD_BB: ctl_o.byte_mode = 1'b1;
      default: ctl_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/mmu_extend.sv
module mmu_extend #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] data_i,
  input  logic          signed_i,
  output logic [DW:0]   data_o
);
  assign data_o = {signed_i & data_i[DW-1], data_i};
endmodule

// File: rtl/mmu_core.sv
module mmu_core #(
  parameter int CW = 17
) (
  input  logic signed [CW-1:0]   a_i,
  input  logic signed [CW-1:0]   b_i,
  output logic signed [2*CW-1:0] p_o
);
  assign p_o = a_i * b_i;
endmodule

// File: rtl/mixed_mul_unit.sv
module mixed_mul_unit
  import mmu_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 5,
  parameter int BW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      mode_i,
  input  logic [DW-1:0]   op_a_i,
  input  logic [DW-1:0]   op_b_i,
  input  logic [LW-1:0]   lit_i,
  output logic [2*DW-1:0] product_o,
  output logic            valid_o
);
  localparam int CW = DW + 1;
  localparam int PW = 2 * DW;
  localparam int BPW = 2 * BW;

  logic [DW-1:0] a_q, b_q;
  logic [LW-1:0] lit_q;
  mode_e         mode_q;
  logic          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      lit_q   <= '0;
      mode_q  <= MD_RSV;
      valid_q <= 1'b0;
    end else begin
      valid_q <= start_i;
      if (start_i) begin
        a_q    <= op_a_i;
        b_q    <= op_b_i;
        lit_q  <= lit_i;
        mode_q <= mode_e'(mode_i);
      end
    end
  end

  ctl_t ctl;
  mmu_decode u_decode (.mode_i(mode_q), .ctl_o(ctl));

  // operand selection ahead of the sign bit
  logic [DW-1:0] a_sel, b_sel;
  always_comb begin
    a_sel = a_q;
    b_sel = b_q;
    if (ctl.byte_mode) begin
      a_sel = {{(DW-BW){1'b0}}, a_q[BW-1:0]};
      b_sel = {{(DW-BW){1'b0}}, b_q[BW-1:0]};
    end else if (ctl.b_lit) begin
      b_sel = {{(DW-LW){1'b0}}, lit_q};
    end
  end

  logic [CW-1:0] a_ext, b_ext;
  mmu_extend #(.DW(DW)) u_ext_a (.data_i(a_sel), .signed_i(ctl.a_signed), .data_o(a_ext));
  mmu_extend #(.DW(DW)) u_ext_b (.data_i(b_sel), .signed_i(ctl.b_signed), .data_o(b_ext));

  logic signed [2*CW-1:0] core_p;
  mmu_core #(.CW(CW)) u_core (.a_i(a_ext), .b_i(b_ext), .p_o(core_p));

  logic [1:0] unused_core_hi;
  assign unused_core_hi = core_p[2*CW-1:PW];

  always_comb begin
    if (!ctl.legal)
      product_o = '0;
    else if (ctl.byte_mode)
      product_o = {{(PW-BPW){1'b0}}, core_p[BPW-1:0]};
    else
      product_o = core_p[PW-1:0];
  end

  assign valid_o = valid_q;

  p_valid_after_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  p_no_stray_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  p_hold_product_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(product_o));
  p_reserved_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == 3'd7) |=> (valid_o && product_o == '0));
  p_byte_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == 3'd6) |=> (product_o[PW-1:BPW] == '0));
  p_sign_ss_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == 3'd0 && op_a_i != '0 && op_b_i != '0)
      |=> (product_o[PW-1] == ($past(op_a_i[DW-1]) ^ $past(op_b_i[DW-1]))));
  p_unsigned_no_neg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == 3'd1 && (op_a_i[DW-1] == 1'b0 || op_b_i[DW-1] == 1'b0))
      |=> !product_o[PW-1]);
endmodule

// File: tb/tb_mixed_mul_unit.sv
module tb_mixed_mul_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [4:0]  lit = '0;
  logic [31:0] product;
  logic        valid;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mixed_mul_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .op_a_i(op_a), .op_b_i(op_b), .lit_i(lit),
    .product_o(product), .valid_o(valid)
  );

  function automatic logic [31:0] model(int m, logic [15:0] a, logic [15:0] b, logic [4:0] l);
    longint x, y, r;
    case (m)
      0: begin x = longint'($signed(a)); y = longint'($signed(b)); end
      1: begin x = longint'(a); y = longint'(b); end
      2: begin x = longint'(a); y = longint'($signed(b)); end
      3: begin x = longint'($signed(a)); y = longint'(b); end
      4: begin x = longint'($signed(a)); y = longint'(l); end
      5: begin x = longint'(a); y = longint'(l); end
      6: begin x = longint'(a[7:0]); y = longint'(b[7:0]); end
      default: begin x = 0; y = 0; end
    endcase
    r = x * y;
    return r[31:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one multiply, result sampled at the negedge after the capturing edge
  task automatic run(string req, int m, logic [15:0] a, logic [15:0] b, logic [4:0] l);
    @(negedge clk);
    mode = 3'(m); op_a = a; op_b = b; lit = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " valid"}, {31'd0, valid}, 32'd1);
    check(req, product, model(m, a, b, l));
  endtask

  task automatic t_reset();
    check("R8 reset valid", {31'd0, valid}, 32'd0);
    check("R8 reset product", product, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 post-reset valid", {31'd0, valid}, 32'd0);
  endtask

  task automatic t_signed();
    run("R1 -3*5", 0, 16'hFFFD, 16'd5, 5'd0);
    run("R1 min*min", 0, 16'h8000, 16'h8000, 5'd0);
    check("R1 min*min value", product, 32'h4000_0000);
    run("R1 max*min", 0, 16'h7FFF, 16'h8000, 5'd0);
  endtask

  task automatic t_unsigned();
    run("R2 ffff*ffff", 1, 16'hFFFF, 16'hFFFF, 5'd0);
    check("R2 ffff*ffff value", product, 32'hFFFE_0001);
    run("R2 1234*5678", 1, 16'h1234, 16'h5678, 5'd0);
  endtask

  task automatic t_mixed();
    run("R3 us ffff*-1", 2, 16'hFFFF, 16'hFFFF, 5'd0);
    check("R3 us value", product, 32'hFFFF_0001);
    run("R3 us 2*min", 2, 16'd2, 16'h8000, 5'd0);
    run("R3 su -1*ffff", 3, 16'hFFFF, 16'hFFFF, 5'd0);
    run("R3 su min*ffff", 3, 16'h8000, 16'hFFFF, 5'd0);
  endtask

  task automatic t_literal();
    run("R4 sl -2*31", 4, 16'hFFFE, 16'hBEEF, 5'd31);
    check("R4 sl value", product, 32'hFFFF_FFC2);
    run("R4 ul ffff*31", 5, 16'hFFFF, 16'h1357, 5'd31);
    check("R4 ul value", product, 32'h001E_FFE1);
    run("R4 ul b ignored", 5, 16'hFFFF, 16'h0000, 5'd31);
    check("R4 ul b ignored value", product, 32'h001E_FFE1);
  endtask

  task automatic t_byte();
    run("R5 byte ff*ff", 6, 16'h12FF, 16'hABFF, 5'd3);
    check("R5 byte value", product, 32'h0000_FE01);
    run("R5 byte 80*03", 6, 16'hFF80, 16'h8003, 5'd0);
  endtask

  task automatic t_reserved();
    run("R6 reserved", 7, 16'hFFFF, 16'hFFFF, 5'd31);
  endtask

  task automatic t_timing();
    @(negedge clk);
    mode = 3'd1; op_a = 16'd7; op_b = 16'd9; start = 1'b1;
    @(negedge clk);
    check("R7 b2b first valid", {31'd0, valid}, 32'd1);
    check("R7 b2b first", product, 32'd63);
    mode = 3'd0; op_a = 16'hFFFF; op_b = 16'd100;
    @(negedge clk);
    start = 1'b0;
    check("R7 b2b second valid", {31'd0, valid}, 32'd1);
    check("R7 b2b second", product, 32'hFFFF_FF9C);
    @(negedge clk);
    check("R7 valid drops", {31'd0, valid}, 32'd0);
  endtask

  task automatic t_hold();
    run("R9 setup", 1, 16'd300, 16'd200, 5'd0);
    for (int i = 0; i < 5; i++) begin
      mode = 3'(i); op_a = 16'(i * 4111); op_b = 16'(i * 777); lit = 5'(i);
      @(negedge clk);
      check("R9 held", product, 32'd60000);
      check("R9 no valid", {31'd0, valid}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_signed();
    t_unsigned();
    t_mixed();
    t_literal();
    t_byte();
    t_reserved();
    t_timing();
    t_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule